// File: doc/BRIEF.md
# NAND Prefetch and Write-Post FIFO Engine

The engine streams a programmed number of bytes between a NAND data port (8 or 16 bits wide) and a 32-bit host data port through a 64-byte FIFO. It has two directions. In prefetch mode it strobes bytes out of the NAND port whenever the FIFO has room, and the host drains them as whole little-endian words. In write-post mode the host pushes words and the engine feeds their bytes to the NAND port, lowest byte first.

Software runs the engine through four word registers on a simple write strobe plus a combinational read mux. A setup word holds the chip select, the direction, a FIFO threshold and an enable. A length word holds the byte count. A run word starts and stops the engine. A read-only progress word reports the remaining byte count and the current FIFO fill. The threshold drives a host request line: in prefetch mode it rises when enough bytes are buffered, and in write-post mode when enough space is free. Writing zero to the run word aborts a transfer at any point. When a transfer ends, the run word clears by itself.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset the run word, the progress word and the setup word read 0, and the NAND strobes and the host request are low.
- R2: The setup word (register select 0) has the chip select at bits 31:24, the threshold at bits 14:8, the enable at bit 7 and the direction at bit 0 (0 = prefetch, 1 = write-post); the other bits read 0. A threshold written above the FIFO depth (64) is stored as 64.
- R3: Writing a word with bit 0 set to the run register (select 2) starts a transfer only if the stored enable is 1. The run word then reads 1, and the progress count is loaded with the length word (select 1, bits 13:0). With the enable at 0 the write has no effect.
- R4: In prefetch mode the engine issues one NAND read strobe per cycle while the remaining count is non-zero and the free FIFO space is at least one beat. Each strobe lowers the remaining count by one beat and raises the fill by one beat.
- R5: The fill never exceeds 64. With the host idle, fetching stops at a full FIFO, leaving length minus 64 bytes remaining.
- R6: A host read pops 4 bytes, the oldest byte in bits 7:0. It is ignored while fewer than 4 bytes are buffered and bytes are still to come. Once the remaining count is zero, a read takes the last 1 to 3 bytes, with the upper bytes returned as 0.
- R7: In prefetch mode the run word returns to 0 one cycle after the remaining count and the fill both reach zero.
- R8: In write-post mode a host write pushes 4 bytes when at least 4 bytes are free. The engine sends the buffered bytes to the NAND port in push order while the remaining count is non-zero. When the count reaches zero the run word clears and any surplus bytes are discarded.
- R9: Writing a word with bit 0 clear to the run register stops the engine at any time. The run word, the remaining count and the fill read 0 from the next cycle on, and no NAND strobe follows.
- R10: Writes to the setup and length words are ignored while a transfer runs.
- R11: The host request is high in prefetch mode when the fill is at least the threshold, high in write-post mode when the free space is at least the threshold, and low when idle.
- R12: The progress word (select 3) holds the remaining count in bits 13:0 and the fill in bits 30:24, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 setup, 1 length, 2 run, 3 progress |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected word (combinational) |
| host_rd_i | input | 1 | Host word pop (prefetch mode) |
| host_rdata_o | output | 32 | Oldest four FIFO bytes, little-endian |
| host_wr_i | input | 1 | Host word push (write-post mode) |
| host_wdata_i | input | 32 | Host word to push |
| host_req_o | output | 1 | Threshold request to the host |
| nand_cs_o | output | 8 | Chip select value from the setup word |
| nand_rd_o | output | 1 | NAND read strobe; data sampled this cycle |
| nand_rdata_i | input | NAND_W | NAND read data |
| nand_wr_o | output | 1 | NAND write strobe |
| nand_wdata_o | output | NAND_W | NAND write data |

## Verification
A register write counts at the clock edge it is presented on. A start is visible in the run word and the progress word at the next sample point. The first NAND strobe falls in the cycle after the start, so the fill read k sample points after the start is k, until it saturates at 64. A host pop takes effect at the following edge. The run word clears one edge after the last pop. An abort shows as all-zero state at the sample right after its write edge. The bench drives every input at the falling edge and reads outputs shortly after it, so each check is taken after exactly the number of edges counted above.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_RUN   = 2'd2,
        SEL_PROG  = 2'd3
    } reg_sel_e;

    localparam int LEN_W = 14;
    localparam int THR_W = 7;

    typedef struct packed {
        logic [7:0]       cs;
        logic [THR_W-1:0] thr;
        logic             en;
        logic             dir;   // 0 prefetch, 1 write-post
    } pf_setup_t;

    function automatic logic [31:0] setup_word(pf_setup_t s);
        return {s.cs, 9'b0, s.thr, s.en, 6'b0, s.dir};
    endfunction

endpackage

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic [NW-1:0]      push_n_i,
    input  logic [LANES*8-1:0] push_data_i,
    input  logic [NW-1:0]      pop_n_i,
    output logic [CW-1:0]      fill_o,
    output logic [LANES*8-1:0] head_o
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] fill;
    } ptr_t;

    ptr_t q, d;
    logic [7:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (flush_i) begin
            d = '0;
        end else begin
            d.wp   = q.wp + AW'(push_n_i);
            d.rp   = q.rp + AW'(pop_n_i);
            d.fill = q.fill + CW'(push_n_i) - CW'(pop_n_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < LANES; i++) begin
            if (NW'(i) < push_n_i)
                mem[q.wp + AW'(i)] <= push_data_i[i*8 +: 8];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_o[g*8 +: 8] = (CW'(g) < q.fill) ? mem[q.rp + AW'(g)] : 8'h00;
    end

    assign fill_o = q.fill;

endmodule

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
    import nand_pf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NAND_W = 8,
    localparam int NB = NAND_W / 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [31:0]       host_wdata_i,
    output logic              host_req_o,
    input  logic [NAND_W-1:0] nand_rdata_i,
    output logic              nand_rd_o,
    output logic              nand_wr_o,
    output logic [7:0]        nand_cs_o,
    input  logic [CW-1:0]     fill_i,
    output logic              flush_o,
    output logic [NW-1:0]     push_n_o,
    output logic [31:0]       push_data_o,
    output logic [NW-1:0]     pop_n_o,
    output logic              busy_o,
    output logic [LEN_W-1:0]  rem_o,
    output logic [THR_W-1:0]  thr_o
);

    typedef struct packed {
        pf_setup_t        setup;
        logic [LEN_W-1:0] len;
        logic             busy;
        logic [LEN_W-1:0] rem;
    } st_t;

    st_t q, d;
    reg_sel_e sel;
    logic [CW-1:0] free;
    logic rd_mode, wr_mode, rem_nz, beat_rd, beat_wr, tail, host_pop, host_push;
    logic [NW-1:0] pop_cnt;
    logic [THR_W-1:0] thr_in;
    logic unused_wbits;

    assign sel          = reg_sel_e'(reg_addr_i);
    assign unused_wbits = ^{reg_wdata_i[23:15], reg_wdata_i[6:1]};
    assign free         = CW'(DEPTH) - fill_i;
    assign rd_mode      = q.busy & ~q.setup.dir;
    assign wr_mode      = q.busy &  q.setup.dir;
    assign rem_nz       = (q.rem != '0);
    assign beat_rd      = rd_mode & rem_nz & (free >= CW'(NB));
    assign beat_wr      = wr_mode & rem_nz & (fill_i >= CW'(NB));
    assign tail         = ~rem_nz & (fill_i != '0);
    assign host_pop     = rd_mode & host_rd_i & ((fill_i >= CW'(4)) | tail);
    assign host_push    = wr_mode & host_wr_i & (free >= CW'(4));
    assign pop_cnt      = (fill_i >= CW'(4)) ? NW'(4) : NW'(fill_i[1:0]);
    assign thr_in       = (reg_wdata_i[14:8] > THR_W'(DEPTH)) ? THR_W'(DEPTH) : reg_wdata_i[14:8];

    always_comb begin
        d        = q;
        flush_o  = 1'b0;
        push_n_o = beat_rd ? NW'(NB) : (host_push ? NW'(4) : '0);
        pop_n_o  = host_pop ? pop_cnt : (beat_wr ? NW'(NB) : '0);
        push_data_o = beat_rd ? 32'(nand_rdata_i) : host_wdata_i;

        if (beat_rd || beat_wr)
            d.rem = (q.rem > LEN_W'(NB)) ? q.rem - LEN_W'(NB) : '0;

        if ((rd_mode && !rem_nz && fill_i == '0) || (wr_mode && !rem_nz)) begin
            d.busy  = 1'b0;
            flush_o = 1'b1;
        end

        if (reg_wr_i) begin
            unique case (sel)
                SEL_SETUP: if (!q.busy) begin
                    d.setup.cs  = reg_wdata_i[31:24];
                    d.setup.thr = thr_in;
                    d.setup.en  = reg_wdata_i[7];
                    d.setup.dir = reg_wdata_i[0];
                end
                SEL_LEN: if (!q.busy) d.len = reg_wdata_i[LEN_W-1:0];
                SEL_RUN: begin
                    if (reg_wdata_i[0]) begin
                        if (!q.busy && q.setup.en) begin
                            d.busy  = 1'b1;
                            d.rem   = q.len;
                            flush_o = 1'b1;
                        end
                    end else begin
                        d.busy  = 1'b0;
                        d.rem   = '0;
                        flush_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        unique case (sel)
            SEL_SETUP: reg_rdata_o = setup_word(q.setup);
            SEL_LEN:   reg_rdata_o = 32'(q.len);
            SEL_RUN:   reg_rdata_o = {31'b0, q.busy};
            default:   reg_rdata_o = {1'b0, 7'(fill_i), 10'b0, q.rem};
        endcase
    end

    assign host_req_o = rd_mode ? (fill_i >= CW'(q.setup.thr)) :
                        wr_mode ? (free   >= CW'(q.setup.thr)) : 1'b0;
    assign nand_rd_o  = beat_rd;
    assign nand_wr_o  = beat_wr;
    assign nand_cs_o  = q.setup.cs;
    assign busy_o     = q.busy;
    assign rem_o      = q.rem;
    assign thr_o      = q.setup.thr;

endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
    import nand_pf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NAND_W = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              host_rd_i,
    output logic [31:0]       host_rdata_o,
    input  logic              host_wr_i,
    input  logic [31:0]       host_wdata_i,
    output logic              host_req_o,
    output logic [7:0]        nand_cs_o,
    output logic              nand_rd_o,
    input  logic [NAND_W-1:0] nand_rdata_i,
    output logic              nand_wr_o,
    output logic [NAND_W-1:0] nand_wdata_o
);

    logic [CW-1:0]    fill_w;
    logic             flush_w, active_w;
    logic [2:0]       push_n_w, pop_n_w;
    logic [31:0]      push_data_w, head_w;
    logic [LEN_W-1:0] rem_w;
    logic [THR_W-1:0] thr_w;

    nand_pf_ctrl #(.DEPTH(DEPTH), .NAND_W(NAND_W)) ctrl_i (
        .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
        .host_rd_i, .host_wr_i, .host_wdata_i, .host_req_o,
        .nand_rdata_i, .nand_rd_o, .nand_wr_o, .nand_cs_o,
        .fill_i(fill_w), .flush_o(flush_w), .push_n_o(push_n_w),
        .push_data_o(push_data_w), .pop_n_o(pop_n_w),
        .busy_o(active_w), .rem_o(rem_w), .thr_o(thr_w)
    );

    nand_pf_fifo #(.DEPTH(DEPTH), .LANES(4)) fifo_i (
        .clk_i, .rst_ni, .flush_i(flush_w), .push_n_i(push_n_w),
        .push_data_i(push_data_w), .pop_n_i(pop_n_w),
        .fill_o(fill_w), .head_o(head_w)
    );

    assign host_rdata_o = head_w;
    assign nand_wdata_o = head_w[NAND_W-1:0];

endmodule

// File: rtl/nand_pf_checker.sv
module nand_pf_checker #(
    parameter int DEPTH = 64,
    parameter int NB    = 1,
    parameter int CW    = 7,
    parameter int LW    = 14
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          active_i,
    input logic [CW-1:0] fill_i,
    input logic [LW-1:0] rem_i,
    input logic [6:0]    thr_i,
    input logic          nand_rd_i,
    input logic          nand_wr_i,
    input logic          stop_i
);

    AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_i <= CW'(DEPTH)); // R5

    AST_ROOM_FOR_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nand_rd_i |-> (CW'(DEPTH) - fill_i) >= CW'(NB)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |-> (!nand_rd_i && !nand_wr_i)); // R9

    AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!active_i && fill_i == '0 && rem_i == '0)); // R9

    AST_REM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((nand_rd_i || nand_wr_i) && !stop_i) |=>
            rem_i == (($past(rem_i) > LW'(NB)) ? $past(rem_i) - LW'(NB) : '0)); // R4

    AST_THR_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_i <= 7'(DEPTH)); // R2

    AST_SETUP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && $past(active_i)) |-> $stable(thr_i)); // R10

endmodule

bind nand_pf_engine nand_pf_checker #(
    .DEPTH(DEPTH), .NB(NAND_W / 8), .CW(CW), .LW(nand_pf_pkg::LEN_W)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_w), .fill_i(fill_w),
    .rem_i(rem_w), .thr_i(thr_w), .nand_rd_i(nand_rd_o), .nand_wr_i(nand_wr_o),
    .stop_i(reg_wr_i && reg_addr_i == 2'd2 && !reg_wdata_i[0])
);

// File: tb/nand_pf_engine_tb_top.sv
`timescale 1ns/1ps
module nand_pf_engine_tb_top;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, host_rd = 0, host_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, host_wdata = 0, reg_rdata, host_rdata;
    logic host_req, nand_rd, nand_wr;
    logic [7:0] nand_cs, nand_rdata, nand_wdata;
    int n_chk = 0, n_err = 0;
    int nrd_cnt = 0, cap_n = 0;
    logic [7:0] cap [64];

    always #2.5 clk = ~clk;

    nand_pf_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .host_rd_i(host_rd),
        .host_rdata_o(host_rdata), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
        .host_req_o(host_req), .nand_cs_o(nand_cs), .nand_rd_o(nand_rd),
        .nand_rdata_i(nand_rdata), .nand_wr_o(nand_wr), .nand_wdata_o(nand_wdata)
    );

    function automatic logic [7:0] rpat(int i); return 8'(i * 37 + 11); endfunction
    function automatic logic [7:0] wpat(int i); return 8'(i * 13 + 90); endfunction
    function automatic logic [31:0] mk_setup(int cs, int thr, int en, int dir);
        return (32'(cs) << 24) | (32'(thr) << 8) | (32'(en) << 7) | 32'(dir);
    endfunction

    // NAND port model
    assign nand_rdata = rpat(nrd_cnt);
    always @(posedge clk) begin
        if (nand_rd) nrd_cnt = nrd_cnt + 1;
        if (nand_wr && cap_n < 64) begin cap[cap_n] = nand_wdata; cap_n = cap_n + 1; end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [31:0] v);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rreg(logic [1:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rreg(2, v); chk("R1 run", v, 0);
        rreg(3, v); chk("R1 progress", v, 0);
        rreg(0, v); chk("R1 setup", v, 0);
        chk("R1 strobes/req", {nand_rd, nand_wr, host_req}, 0);
    endtask

    task automatic t_clamp_and_disabled;
        logic [31:0] v;
        wreg(0, mk_setup(8'hA5, 7'h7F, 0, 0) | 32'h0000_8042);
        rreg(0, v); chk("R2 setup readback clamp", v, mk_setup(8'hA5, 64, 0, 0));
        wreg(1, 32'd20);
        wreg(2, 32'd1);
        rreg(2, v); chk("R3 start ignored when disabled", v, 0);
        chk("R3 no strobe", {31'b0, nand_rd}, 0);
    endtask

    task automatic t_prefetch_full;
        logic [31:0] v;
        int base;
        base = nrd_cnt;
        wreg(0, mk_setup(5, 16, 1, 0));
        wreg(1, 32'd100);
        wreg(2, 32'd1);
        rreg(2, v); chk("R3 busy after start", v, 1);
        rreg(3, v); chk("R12 progress after start", v, 32'd100);
        chk("R2 chip select", {24'b0, nand_cs}, 5);
        repeat (69) @(negedge clk);
        rreg(3, v); chk("R5 R12 full fifo", v, (32'd64 << 24) | 32'd36);
        chk("R5 no fetch when full", {31'b0, nand_rd}, 0);
        chk("R4 strobe count", nrd_cnt - base, 64);
        for (int w = 0; w < 25; w++) begin
            rreg(3, v);
            while (v[30:24] < 4 && !(v[13:0] == 0 && v[30:24] != 0)) begin
                @(negedge clk); rreg(3, v);
            end
            chk($sformatf("R6 word %0d", w), host_rdata,
                {rpat(base+4*w+3), rpat(base+4*w+2), rpat(base+4*w+1), rpat(base+4*w)});
            host_rd = 1; @(negedge clk); host_rd = 0;
        end
        @(negedge clk);
        rreg(2, v); chk("R7 self clear", v, 0);
        chk("R4 total strobes", nrd_cnt - base, 100);
    endtask

    task automatic t_prefetch_tail;
        logic [31:0] v;
        int base;
        base = nrd_cnt;
        wreg(1, 32'd6);
        wreg(2, 32'd1);
        repeat (9) @(negedge clk);
        rreg(3, v); chk("R12 tail progress", v, 32'd6 << 24);
        chk("R6 first word", host_rdata, {rpat(base+3), rpat(base+2), rpat(base+1), rpat(base)});
        host_rd = 1; @(negedge clk); host_rd = 0;
        chk("R6 padded tail", host_rdata, {16'h0, rpat(base+5), rpat(base+4)});
        host_rd = 1; @(negedge clk); host_rd = 0;
        rreg(2, v); chk("R7 busy until edge after drain", v, 1);
        @(negedge clk);
        rreg(2, v); chk("R7 clear after drain", v, 0);
    endtask

    task automatic t_ignore_and_abort;
        logic [31:0] v;
        int snap;
        wreg(0, mk_setup(5, 16, 1, 0));
        wreg(1, 32'd200);
        wreg(2, 32'd1);
        host_rd = 1; @(negedge clk); host_rd = 0;
        repeat (19) @(negedge clk);
        rreg(3, v); chk("R6 early pop ignored", v, (32'd20 << 24) | 32'd180);
        wreg(0, mk_setup(9, 4, 1, 1));
        wreg(1, 32'd5);
        rreg(0, v); chk("R10 setup held", v, mk_setup(5, 16, 1, 0));
        rreg(1, v); chk("R10 length held", v, 200);
        wreg(2, 32'd0);
        rreg(2, v); chk("R9 run cleared", v, 0);
        rreg(3, v); chk("R9 progress cleared", v, 0);
        snap = nrd_cnt;
        repeat (5) @(negedge clk);
        chk("R9 no strobes after abort", nrd_cnt - snap, 0);
    endtask

    task automatic t_threshold;
        logic [31:0] v;
        wreg(0, mk_setup(2, 8, 1, 0));
        wreg(1, 32'd20);
        wreg(2, 32'd1);
        rreg(3, v);
        while (v[30:24] != 7) begin @(negedge clk); rreg(3, v); end
        chk("R11 req low below threshold", {31'b0, host_req}, 0);
        @(negedge clk);
        chk("R11 req high at threshold", {31'b0, host_req}, 1);
        wreg(2, 32'd0);
        chk("R11 req low when idle", {31'b0, host_req}, 0);
    endtask

    task automatic t_write_post;
        logic [31:0] v;
        int bad;
        cap_n = 0;
        wreg(0, mk_setup(3, 8, 1, 1));
        wreg(1, 32'd10);
        wreg(2, 32'd1);
        chk("R11 write-post req", {31'b0, host_req}, 1);
        for (int w = 0; w < 3; w++) begin
            host_wr = 1;
            host_wdata = {wpat(4*w+3), wpat(4*w+2), wpat(4*w+1), wpat(4*w)};
            @(negedge clk);
        end
        host_wr = 0;
        repeat (20) @(negedge clk);
        chk("R8 bytes sent", cap_n, 10);
        bad = 0;
        for (int k = 0; k < 10; k++) if (cap[k] !== wpat(k)) bad++;
        chk("R8 byte order", bad, 0);
        rreg(2, v); chk("R8 run cleared", v, 0);
        rreg(3, v); chk("R8 surplus discarded", v, 0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_clamp_and_disabled();
        t_prefetch_full();
        t_prefetch_tail();
        t_ignore_and_abort();
        t_threshold();
        t_write_post();
        finish_run();
    end

endmodule